// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block is the bus-facing half of a single-master I2C controller. A host issues one command at a time: open a transfer with a start condition and an address byte, re-open it with a repeated start, move one data byte, or close the bus with a stop. The engine drives SCL and SDA in open-drain style. Each line has a pull-low enable output, the block never drives a line high, and both lines are read back through input pins. The engine reports the slave's acknowledge after every byte it sends, and the received byte after every byte it reads. Completion is marked by a one-cycle done strobe.

All bus timing comes from two delays, a half period and a quarter period, counted in system clock ticks. Both are derived from the clock frequency parameter, and an input picks normal (100 kHz-class) or fast (400 kHz-class) timing for each command. The slave may stretch SCL during any acknowledge clock, and the engine waits until SCL really reads high there. Commands travel on a valid/ready pair. The host holds `cmd_valid` and the command fields stable until the cycle in which `cmd_ready` is high, and `cmd_ready` is high only while the engine is idle. The engine accepts no back-pressure on its results: `ack_n` and `rx_data` are valid in the cycle `done` is high, and they keep their value until the next command overwrites them.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, neither line is pulled (`scl_pull` = 0, `sda_pull` = 0), `cmd_ready` is 1 and `done` is 0.
- R2: A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` then stays low, and `cmd_valid`, `cmd_op` and `fast_mode` changes are ignored, until the cycle in which `done` is high for exactly one cycle with `cmd_ready` back at 1.
- R3: In normal mode (`fast_mode` = 0) the half period H is CLK_MHZ*5 ticks and the quarter period Q is floor(CLK_MHZ*5/2). In fast mode H is floor(CLK_MHZ*13/10) and Q is floor(CLK_MHZ*6/10). Each value is at least 1. The mode is sampled when the command is taken.
- R4: `cmd_op` = 0 (start): SDA is pulled for Q cycles with SCL released. Then `cmd_byte` is sent as per R6, and the slave acknowledge is collected as per R7.
- R5: `cmd_op` = 1 (repeated start): SCL is pulled with SDA released for H cycles. Both lines are then released for Q cycles, and the R4 sequence follows.
- R6: Bytes go out MSB first. Each bit pulls SCL for H cycles and then releases it for H cycles, with SDA pulled through both halves when the bit is 0 and released when it is 1.
- R7: The slave acknowledge clock pulls SCL with SDA released for H cycles, then releases SCL. On the first cycle SCL reads high, `sda_in` is captured into `ack_n` (0 = acknowledged, 1 = not), and H more released cycles follow.
- R8: A read byte is 8 bit clocks. Each pulls SCL for H cycles with SDA released, then releases SCL for H cycles, and `sda_in` is sampled on the last released cycle. The bits shift into `rx_data` MSB first.
- R9: After a read, the master acknowledge clock pulls SDA when `cmd_rd_ack` = 1 (more data wanted) or releases it when 0 (last byte). SCL is pulled for H, then released until it reads high, then H more cycles follow. SDA holds its level through all of it.
- R10: `cmd_op` = 3 (stop): both lines are pulled for H cycles, SCL is released for Q cycles while SDA stays pulled, then both are released for H cycles.
- R11: Bit 0 of the byte given with `cmd_op` 0 or 1 is latched as the direction. `cmd_op` = 2 then writes `cmd_byte` (R6, R7) when that bit is 0, and reads (R8, R9) when it is 1.
- R12: While SCL stays released across two cycles, SDA changes only to form a start (pull) or a stop (release).
- R13: While idle, both pull outputs keep the levels of the last cycle of the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 start, 1 repeated start, 2 data byte, 3 stop |
| cmd_byte | input | 8 | Address/direction byte or write data |
| cmd_rd_ack | input | 1 | For reads: 1 acknowledge, 0 not-acknowledge |
| fast_mode | input | 1 | 1 selects fast timing |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle completion strobe |
| ack_n | output | 1 | Slave acknowledge of the last byte sent (0 = ACK) |
| rx_data | output | 8 | Last byte read |

## Verification
The bench builds the engine with CLK_MHZ = 2. That gives H = 10 and Q = 5 in normal mode, and H = 2 and Q = 1 in fast mode. With these values a full write, repeated-start and read session in both modes fits in a few thousand cycles, and every phase length can be told apart from its neighbours. The fast mode's one-tick quarter period exercises the shortest timer load. The bench's slave model stretches SCL for several cycles in both acknowledge clocks, answers with both ACK and NACK, and returns data patterns whose bits alternate and repeat, so SDA ordering and sample points are exposed.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_RSTART = 2'd1,
    OP_XFER   = 2'd2,
    OP_STOP   = 2'd3
  } op_e;

  typedef enum logic [4:0] {
    PH_IDLE,
    PH_SDA_FALL,
    PH_RS_LOW,
    PH_RS_REL,
    PH_TX_LOW,
    PH_TX_HIGH,
    PH_SA_LOW,
    PH_SA_WAIT,
    PH_SA_TAIL,
    PH_RX_LOW,
    PH_RX_HIGH,
    PH_MA_LOW,
    PH_MA_WAIT,
    PH_MA_TAIL,
    PH_SP_LOW,
    PH_SP_SCL,
    PH_SP_SDA
  } phase_e;

  function automatic logic uses_quarter(phase_e p);
    return (p == PH_SDA_FALL) || (p == PH_RS_REL) || (p == PH_SP_SCL);
  endfunction

endpackage

// File: rtl/i2c_eng_timer.sv
module i2c_eng_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

  AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R3
  AST_TMR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (len > W'(1))) |=> !zero); // R3

endmodule

// File: rtl/i2c_eng_shreg.sv
module i2c_eng_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= ld_val;
    else if (shift)  q <= {q[W-2:0], sin};
  end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int CLK_MHZ = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_rd_ack,
  input  logic       fast_mode,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       done,
  output logic       ack_n,
  output logic [7:0] rx_data
);

  localparam int BYTE_W = 8;
  localparam int BC_W   = $clog2(BYTE_W);
  localparam int N_HALF = (CLK_MHZ * 5 < 1) ? 1 : CLK_MHZ * 5;
  localparam int N_QTR  = ((CLK_MHZ * 5) / 2 < 1) ? 1 : (CLK_MHZ * 5) / 2;
  localparam int F_HALF = ((CLK_MHZ * 13) / 10 < 1) ? 1 : (CLK_MHZ * 13) / 10;
  localparam int F_QTR  = ((CLK_MHZ * 6) / 10 < 1) ? 1 : (CLK_MHZ * 6) / 10;
  localparam int TW     = $clog2(N_HALF + 1);

  phase_e            ph_q, ph_nx;
  op_e               op;
  logic              adv, accept, last_bit, mode_now;
  logic              fast_q, dir_q, mack_q, ackn_q, done_q;
  logic              hold_scl_q, hold_sda_q;
  logic [BC_W-1:0]   bit_q;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_len;
  logic              sh_load, sh_shift;
  logic [BYTE_W-1:0] sh_q;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (ph_q == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign last_bit  = (bit_q == '0);

  // successor phase
  always_comb begin
    ph_nx = ph_q;
    unique case (ph_q)
      PH_IDLE: begin
        unique case (op)
          OP_START:  ph_nx = PH_SDA_FALL;
          OP_RSTART: ph_nx = PH_RS_LOW;
          OP_XFER:   ph_nx = dir_q ? PH_RX_LOW : PH_TX_LOW;
          default:   ph_nx = PH_SP_LOW;
        endcase
      end
      PH_RS_LOW:   ph_nx = PH_RS_REL;
      PH_RS_REL:   ph_nx = PH_SDA_FALL;
      PH_SDA_FALL: ph_nx = PH_TX_LOW;
      PH_TX_LOW:   ph_nx = PH_TX_HIGH;
      PH_TX_HIGH:  ph_nx = last_bit ? PH_SA_LOW : PH_TX_LOW;
      PH_SA_LOW:   ph_nx = PH_SA_WAIT;
      PH_SA_WAIT:  ph_nx = PH_SA_TAIL;
      PH_RX_LOW:   ph_nx = PH_RX_HIGH;
      PH_RX_HIGH:  ph_nx = last_bit ? PH_MA_LOW : PH_RX_LOW;
      PH_MA_LOW:   ph_nx = PH_MA_WAIT;
      PH_MA_WAIT:  ph_nx = PH_MA_TAIL;
      PH_SP_LOW:   ph_nx = PH_SP_SCL;
      PH_SP_SCL:   ph_nx = PH_SP_SDA;
      default:     ph_nx = PH_IDLE;
    endcase
  end

  // when the current phase ends
  always_comb begin
    unique case (ph_q)
      PH_IDLE:                adv = cmd_valid;
      PH_SA_WAIT, PH_MA_WAIT: adv = scl_in;
      default:                adv = tmr_zero;
    endcase
  end

  assign mode_now = cmd_ready ? fast_mode : fast_q;
  assign tmr_load = adv && (ph_nx != PH_IDLE);
  always_comb begin
    if (uses_quarter(ph_nx)) tmr_len = mode_now ? TW'(F_QTR)  : TW'(N_QTR);
    else                     tmr_len = mode_now ? TW'(F_HALF) : TW'(N_HALF);
  end

  i2c_eng_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .zero(tmr_zero)
  );

  assign sh_load  = accept && (op != OP_STOP) && !((op == OP_XFER) && dir_q);
  assign sh_shift = adv && ((ph_q == PH_TX_HIGH) || (ph_q == PH_RX_HIGH));

  i2c_eng_shreg #(.W(BYTE_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_val(cmd_byte),
    .shift(sh_shift), .sin(sda_in), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      bit_q      <= '0;
      fast_q     <= 1'b0;
      dir_q      <= 1'b0;
      mack_q     <= 1'b0;
      ackn_q     <= 1'b1;
      done_q     <= 1'b0;
      hold_scl_q <= 1'b0;
      hold_sda_q <= 1'b0;
    end else begin
      if (adv) ph_q <= ph_nx;
      if (accept) begin
        bit_q  <= BC_W'(BYTE_W - 1);
        fast_q <= fast_mode;
        if ((op == OP_START) || (op == OP_RSTART)) dir_q <= cmd_byte[0];
        if (op == OP_XFER) mack_q <= cmd_rd_ack;
      end else if (sh_shift) begin
        bit_q <= bit_q - BC_W'(1);
      end
      if (adv && (ph_q == PH_SA_WAIT)) ackn_q <= sda_in;
      done_q <= adv && ((ph_q == PH_SA_TAIL) || (ph_q == PH_MA_TAIL) ||
                        (ph_q == PH_SP_SDA));
      if (!cmd_ready) begin
        hold_scl_q <= scl_pull;
        hold_sda_q <= sda_pull;
      end
    end
  end

  // line levels per phase
  always_comb begin
    unique case (ph_q)
      PH_IDLE:                 {scl_pull, sda_pull} = {hold_scl_q, hold_sda_q};
      PH_SDA_FALL:             {scl_pull, sda_pull} = 2'b01;
      PH_RS_LOW, PH_SA_LOW,
      PH_RX_LOW:               {scl_pull, sda_pull} = 2'b10;
      PH_TX_LOW:               {scl_pull, sda_pull} = {1'b1, ~sh_q[BYTE_W-1]};
      PH_TX_HIGH:              {scl_pull, sda_pull} = {1'b0, ~sh_q[BYTE_W-1]};
      PH_MA_LOW:               {scl_pull, sda_pull} = {1'b1, mack_q};
      PH_MA_WAIT, PH_MA_TAIL:  {scl_pull, sda_pull} = {1'b0, mack_q};
      PH_SP_LOW:               {scl_pull, sda_pull} = 2'b11;
      PH_SP_SCL:               {scl_pull, sda_pull} = 2'b01;
      default:                 {scl_pull, sda_pull} = 2'b00;
    endcase
  end

  assign done    = done_q;
  assign ack_n   = ackn_q;
  assign rx_data = sh_q;

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R2
  AST_STRETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (((ph_q == PH_SA_WAIT) || (ph_q == PH_MA_WAIT)) && !scl_in) |=> (ph_q == $past(ph_q))); // R7
  AST_SDA_ONLY_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull)))
      |-> ((ph_q == PH_SDA_FALL) || (ph_q == PH_SP_SDA))); // R12
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && $past(cmd_ready)) |-> ($stable(scl_pull) && $stable(sda_pull))); // R13

endmodule

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ_TB = 2;
  localparam int HN = CLK_MHZ_TB * 5;
  localparam int QN = (CLK_MHZ_TB * 5) / 2;
  localparam int HF = (CLK_MHZ_TB * 13) / 10;
  localparam int QF = (CLK_MHZ_TB * 6) / 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rd_ack = 1'b0, fast_mode = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_byte = 8'h00;
  logic cmd_ready, scl_pull, sda_pull, done, ack_n;
  logic [7:0] rx_data;
  logic slave_sda = 1'b0, slave_hold = 1'b0;
  logic scl_in, sda_in;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [3:0] exp_q[$];   // {scl_pull, sda_pull, slave pulls SDA, slave holds SCL}

  assign scl_in = !(scl_pull || slave_hold);
  assign sda_in = !(sda_pull || slave_sda);

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_byte_engine #(.CLK_MHZ(CLK_MHZ_TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_rd_ack(cmd_rd_ack),
    .fast_mode(fast_mode), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .done(done), .ack_n(ack_n),
    .rx_data(rx_data)
  );

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(int n, bit scl, bit sda, bit ssda, bit hold);
    for (int k = 0; k < n; k++) exp_q.push_back({scl, sda, ssda, hold});
  endtask

  task automatic model_tx(logic [7:0] b, bit sack, int k, int h);
    for (int i = 7; i >= 0; i--) begin       // R6 MSB first
      push(h, 1, ~b[i], 0, 0);
      push(h, 0, ~b[i], 0, 0);
    end
    push(h, 1, 0, sack, 0);                   // R7
    push(k, 0, 0, sack, 1);
    push(1, 0, 0, sack, 0);
    push(h, 0, 0, sack, 0);
  endtask

  task automatic model_rx(logic [7:0] d, bit mack, int k, int h);
    for (int i = 7; i >= 0; i--) begin       // R8
      push(h, 1, 0, ~d[i], 0);
      push(h, 0, 0, ~d[i], 0);
    end
    push(h, 1, mack, 0, 0);                   // R9
    push(k, 0, mack, 0, 1);
    push(1, 0, mack, 0, 0);
    push(h, 0, mack, 0, 0);
  endtask

  // Issue one command and compare every cycle to exp_q.
  task automatic run(logic [1:0] op, logic [7:0] b, bit rdack, bit fast, bit busy_poke,
                     bit chk_ack, bit exp_ackn, bit chk_rx, logic [7:0] exp_rx, string req);
    int n;
    n = exp_q.size();
    @(negedge clk);
    check(cmd_ready == 1'b1, {req, " R2 ready before take"}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_rd_ack = rdack; fast_mode = fast;
    @(posedge clk);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (busy_poke && i < n) begin            // R2, R3: ignored while busy
        cmd_op = 2'd3; fast_mode = ~fast;
      end else begin
        cmd_valid = 1'b0;
      end
      if (i < n) begin
        slave_sda = exp_q[i][1]; slave_hold = exp_q[i][0];
        check(scl_pull == exp_q[i][3], {req, " scl_pull"}, scl_pull, exp_q[i][3]);
        check(sda_pull == exp_q[i][2], {req, " sda_pull"}, sda_pull, exp_q[i][2]);
        check(!done && !cmd_ready, {req, " R2 busy"}, {done, cmd_ready}, 0);
      end else begin
        cmd_valid = 1'b0; slave_sda = 1'b0; slave_hold = 1'b0; fast_mode = fast;
        check(done && cmd_ready, {req, " R2 done strobe"}, {done, cmd_ready}, 3);
        if (chk_ack) check(ack_n == exp_ackn, {req, " R7 ack_n"}, ack_n, exp_ackn);
        if (chk_rx) check(rx_data == exp_rx, {req, " R8 rx_data"}, rx_data, exp_rx);
      end
    end
    exp_q.delete();
  endtask

  task automatic idle_watch(int n, bit scl, bit sda, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(scl_pull == scl && sda_pull == sda, {req, " R13 idle hold"},
            {scl_pull, sda_pull}, {scl, sda});
      check(!done, {req, " R2 single done"}, done, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl_pull == 0 && sda_pull == 0, "R1 lines released", {scl_pull, sda_pull}, 0);
    check(cmd_ready == 1 && done == 0, "R1 ready/done", {cmd_ready, done}, 2);
    rst_n = 1'b1;
    idle_watch(3, 0, 0, "R1");

    // normal mode: start + write address, slave ACK, no stretch (R4, R6, R7)
    push(QN, 0, 1, 0, 0); model_tx(8'hA0, 1, 0, HN);
    run(2'd0, 8'hA0, 0, 0, 0, 1, 0, 0, 8'h00, "R4 start");
    idle_watch(4, 0, 0, "R4");
    // write data 0x00 with 3-cycle stretch and busy poking (R11 write, R2, R3, R7)
    model_tx(8'h00, 1, 3, HN);
    run(2'd2, 8'h00, 0, 0, 1, 1, 0, 0, 8'h00, "R11 write stretch");
    // write 0x55, slave NACK (R6, R7)
    model_tx(8'h55, 0, 1, HN);
    run(2'd2, 8'h55, 0, 0, 0, 1, 1, 0, 8'h00, "R7 nack");
    // stop (R10)
    push(HN, 1, 1, 0, 0); push(QN, 0, 1, 0, 0); push(HN, 0, 0, 0, 0);
    run(2'd3, 8'h00, 0, 0, 0, 0, 0, 0, 8'h00, "R10 stop");
    idle_watch(3, 0, 0, "R10");

    // fast mode session (R3)
    push(QF, 0, 1, 0, 0); model_tx(8'hA0, 1, 0, HF);
    run(2'd0, 8'hA0, 0, 1, 0, 1, 0, 0, 8'h00, "R3 fast start");
    model_tx(8'h3C, 1, 2, HF);
    run(2'd2, 8'h3C, 0, 1, 0, 1, 0, 0, 8'h00, "R3 fast write");
    // repeated start with read address (R5, R11)
    push(HF, 1, 0, 0, 0); push(QF, 0, 0, 0, 0); push(QF, 0, 1, 0, 0);
    model_tx(8'hA1, 1, 0, HF);
    run(2'd1, 8'hA1, 0, 1, 0, 1, 0, 0, 8'h00, "R5 rstart");
    // read with master ACK and stretch (R8, R9, R11)
    model_rx(8'hC3, 1, 2, HF);
    run(2'd2, 8'h99, 1, 1, 0, 0, 0, 1, 8'hC3, "R9 read ack");
    idle_watch(5, 0, 1, "R9");
    // last read with NACK in normal mode (R8, R9)
    model_rx(8'h5A, 0, 0, HN);
    run(2'd2, 8'h00, 0, 0, 0, 0, 0, 1, 8'h5A, "R8 read nack");
    push(HN, 1, 1, 0, 0); push(QN, 0, 1, 0, 0); push(HN, 0, 0, 0, 0);
    run(2'd3, 8'h00, 0, 0, 0, 0, 0, 0, 8'h00, "R10 stop after read");
    idle_watch(3, 0, 0, "R13");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule